// File: doc/BRIEF.md
# STS-1 Transmit Overhead Inserter and Frame Scrambler

This block sits on the transmit side of an STS-1 line interface. It takes a byte stream of 9 rows by 90 columns, one byte per valid cycle, with a start-of-frame marker on the first byte. It keeps track of the row and column position itself, writes the framing and identity bytes into row 1, and runs the frame-synchronous scrambler over every other byte. It also carries two bit-interleaved parity results forward from one frame into the next.

The line parity (B2) covers the line overhead and the payload envelope before scrambling. The section parity (B1) covers every byte of the frame after scrambling. Each result is written into its own overhead byte in the following frame, and that byte is then scrambled. Diagnostic controls can do the following: force line AIS, signal line RDI in K2, invert either inserted parity byte, corrupt the A1 framing byte, disable the scrambler, and blank the output to zeros. The output is the processed byte one clock after the input.

Top module: `sts1_tx_ohscr`

## Requirements
- R1: The output byte for row 1 column 1 is 0xF6, for column 2 it is 0x28 and for column 3 it is 0x01. These three bytes are never scrambled.
- R2: The scrambler is a 7-stage generator for 1+x^6+x^7. Keystream bit = stage 7. New stage 1 = stage 7 XOR stage 6. Bits are used MSB first. It reloads to all ones so that the byte after the row 1 column 3 byte uses keystream 0xFE. It advances once per scrambled byte, and output = byte XOR keystream.
- R3: With `scr_en` low, every byte leaves unscrambled. The generator still advances as in R2.
- R4: The byte at row 5 column 1 is, before scrambling, the XOR of every pre-scramble byte of the previous complete frame that lies in rows 4 to 9 of columns 1 to 3 or in columns 4 to 90. It is 0x00 before the first complete frame.
- R5: The byte at row 2 column 1 is, before scrambling, the XOR of all 810 scrambled bytes of the previous complete frame. This is taken before the zero substitution of R10. It is 0x00 before the first complete frame.
- R6: `b1_inv` and `b2_inv` invert all eight bits of the inserted B1 and B2 values.
- R7: `frm_err` sends the A1 byte as 0xF6 XOR 0x01 = 0xF7.
- R8: `ais_en` sets every byte of the R4 region to 0xFF before scrambling, including B2 and K2. Section overhead is not affected.
- R9: `rdi_en`, with AIS off, forces the low three bits of K2 (row 5 column 3) to 110. The upper five bits pass through.
- R10: `zero_en` drives 0x00 on `out_data` for every valid byte. Scrambling and B1 are not affected.
- R11: `out_valid`, `out_sof` and `out_data` follow the input by exactly one clock. Idle cycles (`in_valid` low) do not move the position. After reset `out_valid` is 0.
- R12: `in_sof` restarts the position at row 1 column 1 and clears both accumulators. The carried parity values change only when a frame runs to row 9 column 90.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input byte present |
| in_sof | input | 1 | Byte is row 1 column 1 |
| in_data | input | 8 | Input byte |
| scr_en | input | 1 | Scrambler enable |
| ais_en | input | 1 | Force line AIS |
| rdi_en | input | 1 | Signal line RDI in K2 |
| b1_inv | input | 1 | Invert inserted B1 |
| b2_inv | input | 1 | Invert inserted B2 |
| frm_err | input | 1 | Corrupt A1 |
| zero_en | input | 1 | Blank output to zeros |
| out_valid | output | 1 | Output byte present |
| out_sof | output | 1 | Output byte is row 1 column 1 |
| out_data | output | 8 | Output byte |

## Verification
The bench goes after the parity carry-over. A design that computed B1 before scrambling, or B2 after it, or that included section overhead in B2, shows wrong bytes at rows 2 and 5 of the following frame. A truncated frame tests R12: a design that latched parity at the next start marker would insert a partial-frame value. Idle gaps inside a frame catch a position counter that advances without data. An all-zero input frame exposes the scrambler sequence and the point where it reloads, and AIS, RDI, inversion and blanking are each run over a whole frame.

// File: rtl/sts1_ohscr_pkg.sv
package sts1_ohscr_pkg;

   localparam int SCR_W = 7;

   typedef struct packed {
      logic [7:0]       ks;
      logic [SCR_W-1:0] nxt;
   } scr_out_t;

   // eight serial steps of 1+x^6+x^7, MSB of the byte first
   function automatic scr_out_t scr_step(input logic [SCR_W-1:0] s);
      scr_out_t         r;
      logic [SCR_W-1:0] st;
      st = s;
      r.ks = '0;
      for (int i = 0; i < 8; i++) begin
         r.ks[7-i] = st[SCR_W-1];
         st = {st[SCR_W-2:0], st[SCR_W-1] ^ st[SCR_W-2]};
      end
      r.nxt = st;
      return r;
   endfunction

endpackage

// File: rtl/sts_pos_ctr.sv
module sts_pos_ctr #(
   parameter int ROWS = 9,
   parameter int COLS = 90,
   localparam int RW = $clog2(ROWS),
   localparam int CW = $clog2(COLS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          adv,
   input  logic          sof,
   output logic [RW-1:0] row,
   output logic [CW-1:0] col,
   output logic          last
);
   localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
   localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

   logic [RW-1:0] row_q;
   logic [CW-1:0] col_q;

   assign row  = sof ? '0 : row_q;
   assign col  = sof ? '0 : col_q;
   assign last = (row == LAST_ROW) && (col == LAST_COL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else if (adv) begin
         if (last) begin
            row_q <= '0;
            col_q <= '0;
         end else if (col == LAST_COL) begin
            row_q <= row + 1'b1;
            col_q <= '0;
         end else begin
            row_q <= row;
            col_q <= col + 1'b1;
         end
      end
   end
endmodule

// File: rtl/sts_frm_scr.sv
module sts_frm_scr
   import sts1_ohscr_pkg::*;
#(
   parameter logic [SCR_W-1:0] SEED = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       step,
   input  logic       reload,
   output logic [7:0] ks
);
   logic [SCR_W-1:0] state;
   scr_out_t         nx;

   assign nx = scr_step(state);
   assign ks = nx.ks;

   always_ff @(posedge clk) begin
      if (!rst_n)      state <= SEED;
      else if (reload) state <= SEED;
      else if (step)   state <= nx.nxt;
   end
endmodule

// File: rtl/sts_bip8.sv
module sts_bip8 #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         vld,
   input  logic         sof,
   input  logic         last,
   input  logic         take,
   input  logic [W-1:0] d,
   output logic [W-1:0] hold
);
   logic [W-1:0] acc, acc_nx;

   assign acc_nx = (sof ? '0 : acc) ^ (take ? d : '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc  <= '0;
         hold <= '0;
      end else if (vld) begin
         if (last) begin
            hold <= acc_nx;
            acc  <= '0;
         end else begin
            acc  <= acc_nx;
         end
      end
   end
endmodule

// File: rtl/sts1_tx_ohscr.sv
module sts1_tx_ohscr
   import sts1_ohscr_pkg::*;
#(
   parameter int               ROWS         = 9,
   parameter int               COLS         = 90,
   parameter int               OH_COLS      = 3,
   parameter int               LOH_ROW      = 3,
   parameter int               B1_ROW       = 1,
   parameter int               B2_ROW       = 4,
   parameter int               K2_ROW       = 4,
   parameter int               K2_COL       = 2,
   parameter logic [7:0]       A1_VAL       = 8'hF6,
   parameter logic [7:0]       A2_VAL       = 8'h28,
   parameter logic [7:0]       C1_VAL       = 8'h01,
   parameter logic [7:0]       FRM_ERR_MASK = 8'h01,
   parameter logic [2:0]       RDI_PAT      = 3'b110,
   parameter logic [SCR_W-1:0] SCR_SEED     = '1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       in_valid,
   input  logic       in_sof,
   input  logic [7:0] in_data,
   input  logic       scr_en,
   input  logic       ais_en,
   input  logic       rdi_en,
   input  logic       b1_inv,
   input  logic       b2_inv,
   input  logic       frm_err,
   input  logic       zero_en,
   output logic       out_valid,
   output logic       out_sof,
   output logic [7:0] out_data
);
   localparam int RW = $clog2(ROWS);
   localparam int CW = $clog2(COLS);
   localparam int NBIP = 2;

   if (OH_COLS < 3 || OH_COLS >= COLS) begin : g_bad_cols
      $error("overhead columns out of range");
   end
   if (LOH_ROW <= B1_ROW || B2_ROW < LOH_ROW || K2_ROW < LOH_ROW || B2_ROW >= ROWS || K2_ROW >= ROWS) begin : g_bad_rows
      $error("overhead row layout inconsistent");
   end
   if (K2_COL >= OH_COLS) begin : g_bad_k2
      $error("K2 column outside overhead");
   end

   logic [RW-1:0] row;
   logic [CW-1:0] col;
   logic          last, row0, is_fr, is_line;
   logic [7:0]    pre, ks, scr_byte;
   logic [7:0]    b1_hold, b2_hold;

   sts_pos_ctr #(.ROWS(ROWS), .COLS(COLS)) u_pos (
      .clk(clk), .rst_n(rst_n), .adv(in_valid), .sof(in_sof),
      .row(row), .col(col), .last(last)
   );

   assign row0    = (row == '0);
   assign is_fr   = row0 && (col < CW'(3));
   assign is_line = (row >= RW'(LOH_ROW)) || (col >= CW'(OH_COLS));

   always_comb begin
      pre = in_data;
      if (is_fr) begin
         if (col == CW'(0))      pre = A1_VAL ^ (frm_err ? FRM_ERR_MASK : 8'h00);
         else if (col == CW'(1)) pre = A2_VAL;
         else                    pre = C1_VAL;
      end else if (is_line) begin
         if (ais_en)
            pre = 8'hFF;
         else if (row == RW'(B2_ROW) && col == '0)
            pre = b2_hold ^ {8{b2_inv}};
         else if (row == RW'(K2_ROW) && col == CW'(K2_COL) && rdi_en)
            pre = {in_data[7:3], RDI_PAT};
      end else if (row == RW'(B1_ROW) && col == '0) begin
         pre = b1_hold ^ {8{b1_inv}};
      end
   end

   sts_frm_scr #(.SEED(SCR_SEED)) u_scr (
      .clk(clk), .rst_n(rst_n),
      .step(in_valid && !is_fr),
      .reload(in_valid && row0 && col == CW'(2)),
      .ks(ks)
   );

   assign scr_byte = (scr_en && !is_fr) ? (pre ^ ks) : pre;

   // index 0: section parity over scrambled bytes; index 1: line parity before scrambling
   logic [7:0] bip_d    [NBIP];
   logic       bip_take [NBIP];
   logic [7:0] bip_hold [NBIP];

   assign bip_d[0]    = scr_byte;
   assign bip_take[0] = 1'b1;
   assign bip_d[1]    = pre;
   assign bip_take[1] = is_line;

   for (genvar g = 0; g < NBIP; g++) begin : g_bip
      sts_bip8 #(.W(8)) u_bip (
         .clk(clk), .rst_n(rst_n), .vld(in_valid), .sof(in_sof),
         .last(last), .take(bip_take[g]), .d(bip_d[g]), .hold(bip_hold[g])
      );
   end

   assign b1_hold = bip_hold[0];
   assign b2_hold = bip_hold[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_sof   <= 1'b0;
         out_data  <= '0;
      end else begin
         out_valid <= in_valid;
         out_sof   <= in_valid && in_sof;
         out_data  <= in_valid ? (zero_en ? 8'h00 : scr_byte) : 8'h00;
      end
   end
endmodule

// File: rtl/sts1_tx_ohscr_chk.sv
module sts1_tx_ohscr_chk #(
   parameter logic [7:0] A1_VAL       = 8'hF6,
   parameter logic [7:0] FRM_ERR_MASK = 8'h01
) (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_sof,
   input logic       frm_err,
   input logic       zero_en,
   input logic       out_valid,
   input logic       out_sof,
   input logic [7:0] out_data
);
   // R11
   valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   // R11
   idle_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   // R11
   sof_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> out_sof);
   // R1
   a1_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && !zero_en && !frm_err) |=> (out_data == A1_VAL));
   // R7
   a1_corrupt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && !zero_en && frm_err) |=> (out_data == (A1_VAL ^ FRM_ERR_MASK)));
   // R10
   zero_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_en) |=> (out_data == 8'h00));
endmodule

bind sts1_tx_ohscr sts1_tx_ohscr_chk #(.A1_VAL(A1_VAL), .FRM_ERR_MASK(FRM_ERR_MASK)) u_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
   .frm_err(frm_err), .zero_en(zero_en), .out_valid(out_valid),
   .out_sof(out_sof), .out_data(out_data)
);

// File: tb/sim_sts1_tx_ohscr.sv
module sim_sts1_tx_ohscr;
   localparam int NR = 9;
   localparam int NC = 90;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0, in_sof = 1'b0;
   logic [7:0] in_data = '0;
   logic scr_en = 1'b0, ais_en = 1'b0, rdi_en = 1'b0, b1_inv = 1'b0;
   logic b2_inv = 1'b0, frm_err = 1'b0, zero_en = 1'b0;
   logic out_valid, out_sof;
   logic [7:0] out_data;

   always #2 clk = ~clk;

   sts1_tx_ohscr u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .scr_en(scr_en), .ais_en(ais_en), .rdi_en(rdi_en),
      .b1_inv(b1_inv), .b2_inv(b2_inv), .frm_err(frm_err), .zero_en(zero_en),
      .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
   );

   int errors = 0, checks = 0;
   bit done = 0;

   // controls applied together with the next byte
   bit c_scr = 1, c_ais = 0, c_rdi = 0, c_b1i = 0, c_b2i = 0, c_frm = 0, c_zero = 0;
   string ph = "R2";

   // reference model state
   int mr = 0, mc = 0;
   int lf = 127;
   int b1a = 0, b2a = 0, b1h = 0, b2h = 0;

   bit exp_v = 0, exp_s = 0;
   int exp_d = 0, exp_r = 0, exp_c = 0;
   string exp_tag = "R2";

   task automatic model(input bit s, input int d);
      int r, c, pre, ks, sc;
      bit line;
      string tag;
      r = s ? 0 : mr;
      c = s ? 0 : mc;
      if (s) begin b1a = 0; b2a = 0; end
      line = (r >= 3) || (c >= 3);
      pre = d;
      tag = "R2";
      if (r == 0 && c < 3) begin
         tag = "R1";
         if (c == 0) begin pre = c_frm ? 'hF7 : 'hF6; if (c_frm) tag = "R7"; end
         else if (c == 1) pre = 'h28;
         else pre = 'h01;
      end else if (line) begin
         if (c_ais) begin pre = 'hFF; tag = "R8"; end
         else if (r == 4 && c == 0) begin pre = b2h ^ (c_b2i ? 'hFF : 0); tag = "R4"; end
         else if (r == 4 && c == 2 && c_rdi) begin pre = (d & 'hF8) | 6; tag = "R9"; end
      end else if (r == 1 && c == 0) begin
         pre = b1h ^ (c_b1i ? 'hFF : 0); tag = "R5";
      end
      ks = 0;
      if (!(r == 0 && c < 3)) begin
         for (int k = 0; k < 8; k++) begin
            int hi, fb;
            hi = (lf >> 6) & 1;
            fb = hi ^ ((lf >> 5) & 1);
            ks = (ks << 1) | hi;
            lf = ((lf << 1) | fb) & 'h7F;
         end
      end
      if (r == 0 && c == 2) lf = 127;
      sc = c_scr ? (pre ^ ks) : pre;
      b1a = b1a ^ sc;
      if (line) b2a = b2a ^ pre;
      if (r == NR - 1 && c == NC - 1) begin
         b1h = b1a; b2h = b2a; b1a = 0; b2a = 0; mr = 0; mc = 0;
      end else if (c == NC - 1) begin
         mr = r + 1; mc = 0;
      end else begin
         mr = r; mc = c + 1;
      end
      exp_d = c_zero ? 0 : sc;
      exp_r = r; exp_c = c; exp_tag = tag;
   endtask

   task automatic compare();
      checks++;
      if (out_valid !== exp_v) begin
         errors++;
         $display("FAIL R11 [%s] out_valid got %b expected %b", ph, out_valid, exp_v);
      end
      if (exp_v) begin
         checks++;
         if (out_data !== 8'(exp_d)) begin
            errors++;
            $display("FAIL %s [%s] row %0d col %0d: got %h expected %h",
                     exp_tag, ph, exp_r + 1, exp_c + 1, out_data, 8'(exp_d));
         end
         checks++;
         if (out_sof !== exp_s) begin
            errors++;
            $display("FAIL R11 [%s] out_sof got %b expected %b", ph, out_sof, exp_s);
         end
      end
   endtask

   task automatic step(input bit v, input bit s, input int d);
      @(negedge clk);
      compare();
      exp_v = v; exp_s = v && s;
      if (v) model(s, d);
      in_valid = v; in_sof = s; in_data = 8'(d);
      scr_en = c_scr; ais_en = c_ais; rdi_en = c_rdi; b1_inv = c_b1i;
      b2_inv = c_b2i; frm_err = c_frm; zero_en = c_zero;
   endtask

   // pat: 0 random, 1 all zeros, 2 all ones
   task automatic frame(input int n, input int pat, input int gap);
      for (int i = 0; i < n; i++) begin
         int d;
         d = (pat == 1) ? 0 : (pat == 2) ? 'hFF : int'($urandom & 'hFF);
         step(1, i == 0, d);
         if (gap > 0 && (i % gap) == gap - 1) step(0, 0, 0);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (out_valid !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset out_valid got %b expected 0", out_valid);
      end
      rst_n = 1'b1;
      // R2 R4 R5: zero data exposes keystream; parity 0 before first full frame
      ph = "R2"; frame(NR * NC, 1, 0);
      ph = "R4 R5"; frame(NR * NC, 0, 0);
      // R11: idle cycles inside the frame
      ph = "R11"; frame(NR * NC, 0, 7);
      // R8
      ph = "R8"; c_ais = 1; frame(NR * NC, 0, 0); c_ais = 0;
      // R9 R6 R7
      ph = "R9"; c_rdi = 1; frame(NR * NC, 1, 0);
      ph = "R6 R7"; c_b1i = 1; c_b2i = 1; c_frm = 1; frame(NR * NC, 0, 0);
      c_rdi = 0; c_b1i = 0; c_b2i = 0; c_frm = 0;
      // R3
      ph = "R3"; c_scr = 0; frame(NR * NC, 2, 0); c_scr = 1;
      // R10
      ph = "R10"; c_zero = 1; frame(NR * NC, 0, 0); c_zero = 0;
      // R12: truncated frame, then two full frames
      ph = "R12"; frame(300, 0, 0); frame(NR * NC, 0, 0); frame(NR * NC, 0, 0);
      step(0, 0, 0);
      step(0, 0, 0);
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule